// File: doc/BRIEF.md
# Split serial access register

This block is the serial-side storage of a video memory: a 512-word by 4-bit register file that exchanges whole rows with the DRAM array on transfer commands and streams words one at a time through a 4-bit serial port. A read transfer fills the register from a row and turns the port into an output. A write transfer hands the register contents back to the array and turns the port into an input. A pseudo transfer only switches the port to input. Each rising edge of the serial clock moves a 9-bit pointer to the next word. A transfer sets the pointer to a tap address.

In split mode the register works as two 256-word halves. A split read transfer refills only the half the pointer is not in, so streaming never stops. When the pointer leaves the end of its half, it continues in the other half at the tap recorded by the last split transfer. A status flag reports which half is in use. The serial clock is a level input. It is synchronous to `clk` and is sampled on every `clk` edge. Its low-to-high change counts as one serial step. The pad tristate sits outside the block, which drives a data output and an output enable.

Top module: `split_sam`

## Requirements
- R1: Each low-to-high change of `sclk` between two `clk` samples advances the pointer by exactly one word, whether or not `ser_en` is high.
- R2: In output mode `sd_out` shows the word at the pointer. After a read transfer the words appear from the tap upward, one per serial step.
- R3: Outside split mode the pointer wraps from 511 to 0.
- R4: `xfer_kind` 0 is a read transfer and sets output mode. 1 is a write transfer and 2 or 3 is a pseudo transfer; both set input mode. Reset leaves input mode.
- R5: `sd_oe` is high only in output mode with `ser_en` high. In input mode a serial step stores `sd_in` at the pointer only when `ser_en` is high.
- R6: In split mode `half_flag` is 0 while the pointer is in words 0..255 and 1 while it is in words 256..511.
- R7: A non-split transfer loads the pointer with `xfer_tap` and sets `half_flag` to `xfer_tap[8]`. Outside split mode the flag then holds while streaming, including across 255 to 256.
- R8: A write transfer raises `row_store_we` in the same cycle as `xfer_req`, with word i of the register on `row_store_data[4i+3:4i]`. A pseudo transfer does not raise it and leaves the contents unchanged. `row_in` uses the same layout.
- R9: A read transfer with `xfer_split` high enters split mode. It loads only the half that does not hold the pointer and leaves the pointer unchanged.
- R10: In split mode a step from the last word of a half goes to the other half at the low 8 bits of the last split tap. That recorded tap then returns to 0. A write or pseudo transfer leaves split mode.
- R11: When a transfer and a serial step fall in the same cycle, the transfer takes effect and the step is dropped.
- R12: After synchronous reset the pointer is 0, `half_flag` is 0, split mode is off and every word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | One-cycle transfer command |
| xfer_kind | input | 2 | 0 read, 1 write, 2/3 pseudo |
| xfer_split | input | 1 | Split request for a read transfer |
| xfer_tap | input | 9 | Tap address for the pointer |
| row_in | input | 2048 | Row data from the array, word i at bits 4i+3:4i |
| row_store_we | output | 1 | Write-back strobe for a write transfer |
| row_store_data | output | 2048 | Register contents for write-back |
| sclk | input | 1 | Serial clock level, synchronous to clk |
| ser_en | input | 1 | Serial port enable |
| sd_in | input | 4 | Serial input word |
| sd_out | output | 4 | Serial output word |
| sd_oe | output | 1 | Serial output enable for the pad |
| half_flag | output | 1 | Active half indicator |

## Verification
A pointer that is off by one or wraps wrongly shows up on `sd_out` at the first step after a read transfer. It also corrupts the contents that the next write transfer puts on `row_store_data`, which catches faults that occurred while the port was an input. A wrong direction or enable decision appears on `sd_oe` in the first cycle after the transfer or enable change. A wrong split tap, crossing rule or half selection changes `half_flag` and `sd_out` at the step that crosses the half boundary. A half that was wrongly refilled shows as wrong words later in the stream. The bench follows every transfer and step with a reference model, so each fault is reported at the first observation after it occurs.

// File: rtl/sam_pkg.sv
package sam_pkg;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } ser_dir_e;

    typedef enum logic [1:0] {
        XF_READ   = 2'd0,
        XF_WRITE  = 2'd1,
        XF_PSEUDO = 2'd2
    } xfer_kind_e;

    typedef struct packed {
        logic valid;
        logic is_read;
        logic is_write;
        logic split;
    } xfer_dec_t;

    // Codes 2 and 3 are both pseudo transfers; split applies to reads only.
    function automatic xfer_dec_t decode_xfer(input logic req,
                                              input logic [1:0] kind,
                                              input logic split_req);
        xfer_dec_t d;
        d.valid    = req;
        d.is_read  = (kind == XF_READ);
        d.is_write = (kind == XF_WRITE);
        d.split    = split_req && (kind == XF_READ);
        return d;
    endfunction

endpackage

// File: rtl/sam_edge_det.sv
module sam_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic step
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign step = sclk && !sclk_q;

    // One level change yields exactly one step.
    assert_single_step_R1: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);

endmodule

// File: rtl/sam_ptr_ctrl.sv
module sam_ptr_ctrl
    import sam_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     rst,
    input  xfer_dec_t                dec,
    input  logic [$clog2(DEPTH)-1:0] tap,
    input  logic                     step_in,
    output logic [$clog2(DEPTH)-1:0] ptr,
    output ser_dir_e                 dir,
    output logic                     split_mode,
    output logic                     half_flag,
    output logic                     load_all,
    output logic                     load_part,
    output logic                     load_half,
    output logic                     step_eff
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-2:0] pend_tap;
    logic          at_half_end;

    assign at_half_end = &ptr[AW-2:0];
    assign step_eff    = step_in && !dec.valid;
    assign load_all    = dec.valid && dec.is_read && !dec.split;
    assign load_part   = dec.valid && dec.is_read && dec.split;
    assign load_half   = ~ptr[AW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= '0;
            dir        <= DIR_IN;
            split_mode <= 1'b0;
            half_flag  <= 1'b0;
            pend_tap   <= '0;
        end else if (dec.valid) begin
            if (dec.is_read && dec.split) begin
                split_mode <= 1'b1;
                dir        <= DIR_OUT;
                pend_tap   <= tap[AW-2:0];
                half_flag  <= ptr[AW-1];
            end else begin
                ptr        <= tap;
                half_flag  <= tap[AW-1];
                split_mode <= 1'b0;
                pend_tap   <= '0;
                dir        <= dec.is_read ? DIR_OUT : DIR_IN;
            end
        end else if (step_in) begin
            if (split_mode && at_half_end) begin
                ptr       <= {~ptr[AW-1], pend_tap};
                pend_tap  <= '0;
                half_flag <= ~ptr[AW-1];
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    assert_step_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (step_eff && !(split_mode && at_half_end)) |=> ptr == $past(ptr) + 1'b1);

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (step_eff && !split_mode && ptr == AW'(DEPTH - 1)) |=> ptr == '0);

    assert_read_dir_R4: assert property (@(posedge clk) disable iff (rst)
        (dec.valid && dec.is_read) |=> dir == DIR_OUT);

    assert_split_flag_R6: assert property (@(posedge clk) disable iff (rst)
        split_mode |-> half_flag == ptr[AW-1]);

    assert_tap_load_R7: assert property (@(posedge clk) disable iff (rst)
        (dec.valid && !(dec.is_read && dec.split))
        |=> (ptr == $past(tap) && half_flag == $past(tap[AW-1])));

    assert_split_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (dec.valid && dec.is_read && dec.split) |=> ptr == $past(ptr));

    assert_cross_R10: assert property (@(posedge clk) disable iff (rst)
        (step_eff && split_mode && at_half_end) |=> ptr[AW-1] != $past(ptr[AW-1]));

    assert_xfer_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (step_in && dec.valid && !dec.split) |=> ptr == $past(tap));

endmodule

// File: rtl/sam_store.sv
module sam_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_all,
    input  logic                     load_part,
    input  logic                     load_half,
    input  logic [DEPTH*WIDTH-1:0]   row_in,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data,
    output logic [DEPTH*WIDTH-1:0]   contents
);
    localparam int HALF = DEPTH / 2;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (load_all || (load_part && ((i >= HALF) == load_half)))
                    mem[i] <= row_in[i*WIDTH +: WIDTH];
            end
            if (wr_en) mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign contents[g*WIDTH +: WIDTH] = mem[g];
    end

    assert_serial_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !load_all && !load_part) |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/split_sam.sv
module split_sam
    import sam_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int WIDTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     xfer_req,
    input  logic [1:0]               xfer_kind,
    input  logic                     xfer_split,
    input  logic [$clog2(DEPTH)-1:0] xfer_tap,
    input  logic [DEPTH*WIDTH-1:0]   row_in,
    output logic                     row_store_we,
    output logic [DEPTH*WIDTH-1:0]   row_store_data,
    input  logic                     sclk,
    input  logic                     ser_en,
    input  logic [WIDTH-1:0]         sd_in,
    output logic [WIDTH-1:0]         sd_out,
    output logic                     sd_oe,
    output logic                     half_flag
);
    localparam int AW = $clog2(DEPTH);

    xfer_dec_t      dec;
    logic           step_raw;
    logic           step_eff;
    logic [AW-1:0]  ptr;
    ser_dir_e       dir;
    logic           split_mode;
    logic           load_all;
    logic           load_part;
    logic           load_half;
    logic           wr_en;

    assign dec = decode_xfer(xfer_req, xfer_kind, xfer_split);

    sam_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .step (step_raw)
    );

    sam_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .tap        (xfer_tap),
        .step_in    (step_raw),
        .ptr        (ptr),
        .dir        (dir),
        .split_mode (split_mode),
        .half_flag  (half_flag),
        .load_all   (load_all),
        .load_part  (load_part),
        .load_half  (load_half),
        .step_eff   (step_eff)
    );

    assign wr_en = step_eff && (dir == DIR_IN) && ser_en;

    sam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .load_all  (load_all),
        .load_part (load_part),
        .load_half (load_half),
        .row_in    (row_in),
        .wr_en     (wr_en),
        .wr_addr   (ptr),
        .wr_data   (sd_in),
        .rd_addr   (ptr),
        .rd_data   (sd_out),
        .contents  (row_store_data)
    );

    assign sd_oe        = (dir == DIR_OUT) && ser_en;
    assign row_store_we = dec.valid && dec.is_write;

    assert_write_to_input_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && xfer_kind != 2'd0) |=> !sd_oe);

    assert_pseudo_no_store_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && xfer_kind[1]) |-> !row_store_we);

endmodule

// File: tb/tb_split_sam.sv
module tb_split_sam;
    localparam int DEPTH = 512;
    localparam int WIDTH = 4;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   xfer_req;
    logic [1:0]             xfer_kind;
    logic                   xfer_split;
    logic [8:0]             xfer_tap;
    logic [DEPTH*WIDTH-1:0] row_in;
    logic                   row_store_we;
    logic [DEPTH*WIDTH-1:0] row_store_data;
    logic                   sclk;
    logic                   ser_en;
    logic [WIDTH-1:0]       sd_in;
    logic [WIDTH-1:0]       sd_out;
    logic                   sd_oe;
    logic                   half_flag;

    always #10 clk = ~clk;

    split_sam #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst(rst), .xfer_req(xfer_req), .xfer_kind(xfer_kind),
        .xfer_split(xfer_split), .xfer_tap(xfer_tap), .row_in(row_in),
        .row_store_we(row_store_we), .row_store_data(row_store_data),
        .sclk(sclk), .ser_en(ser_en), .sd_in(sd_in), .sd_out(sd_out),
        .sd_oe(sd_oe), .half_flag(half_flag)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    logic [3:0] m_mem [DEPTH];
    logic [8:0] m_ptr;
    logic       m_dir;
    logic       m_split;
    logic       m_flag;
    logic [7:0] m_pend;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DEPTH*WIDTH-1:0] model_flat();
        logic [DEPTH*WIDTH-1:0] f;
        for (int i = 0; i < DEPTH; i++) f[i*WIDTH +: WIDTH] = m_mem[i];
        return f;
    endfunction

    function automatic logic [8:0] model_next(input logic [8:0] p);
        if (m_split && p[7:0] == 8'hFF) return {~p[8], m_pend};
        return p + 9'd1;
    endfunction

    task automatic fill_row();
        for (int i = 0; i < DEPTH*WIDTH/32; i++) row_in[i*32 +: 32] = $urandom;
    endtask

    task automatic check_state(input string req);
        check(sd_oe == (m_dir && ser_en), req, 32'(sd_oe), 32'(m_dir && ser_en));
        check(half_flag == m_flag, req, 32'(half_flag), 32'(m_flag));
        if (m_dir && ser_en)
            check(sd_out == m_mem[m_ptr], req, 32'(sd_out), 32'(m_mem[m_ptr]));
    endtask

    task automatic model_xfer(input logic [1:0] kind, input logic split, input logic [8:0] tap);
        if (kind == 2'd0 && split) begin
            for (int i = 0; i < DEPTH; i++)
                if ((i >= DEPTH/2) != m_ptr[8]) m_mem[i] = row_in[i*WIDTH +: WIDTH];
            m_split = 1'b1; m_dir = 1'b1; m_pend = tap[7:0]; m_flag = m_ptr[8];
        end else begin
            if (kind == 2'd0)
                for (int i = 0; i < DEPTH; i++) m_mem[i] = row_in[i*WIDTH +: WIDTH];
            m_ptr = tap; m_flag = tap[8]; m_split = 1'b0; m_pend = 8'h00;
            m_dir = (kind == 2'd0);
        end
    endtask

    task automatic do_xfer(input logic [1:0] kind, input logic split, input logic [8:0] tap);
        @(negedge clk);
        fill_row();
        xfer_req = 1'b1; xfer_kind = kind; xfer_split = split; xfer_tap = tap;
        #1;
        if (kind == 2'd1) begin
            check(row_store_we == 1'b1, "R8 store strobe", 32'(row_store_we), 32'd1);
            check(row_store_data == model_flat(), "R8 store data",
                  32'(row_store_data[31:0]), model_flat()[31:0]);
        end else begin
            check(row_store_we == 1'b0, "R8 no strobe", 32'(row_store_we), 32'd0);
        end
        @(negedge clk);
        xfer_req = 1'b0;
        model_xfer(kind, split, tap);
        #1;
        check_state("R4 R7 after transfer");
    endtask

    task automatic ser_step(input logic [3:0] din, input logic en);
        @(negedge clk);
        ser_en = en;
        #1;
        check_state("R2 R5 R6 before step");
        sd_in = din; sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        if (!m_dir && en) m_mem[m_ptr] = din;
        m_ptr = model_next(m_ptr);
        if (m_split) m_flag = m_ptr[8];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4021));
        rst = 1'b1; xfer_req = 0; xfer_kind = 0; xfer_split = 0; xfer_tap = 0;
        row_in = '0; sclk = 0; ser_en = 1; sd_in = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 4'h0;
        m_ptr = 0; m_dir = 0; m_split = 0; m_flag = 0; m_pend = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 reset state
        check(sd_oe == 1'b0, "R12 reset input mode", 32'(sd_oe), 32'd0);
        check(half_flag == 1'b0, "R12 reset flag", 32'(half_flag), 32'd0);
        do_xfer(2'd1, 1'b0, 9'd0);   // R12 all words zero, seen through write-back

        // R1 R5: input streaming with enable gaps
        for (int k = 0; k < 24; k++) ser_step(4'($urandom), (k % 5) != 2);
        do_xfer(2'd1, 1'b0, 9'd5);   // R8 write-back reflects R5 gating
        do_xfer(2'd2, 1'b0, 9'd300); // R8 pseudo: no strobe
        for (int k = 0; k < 6; k++) ser_step(4'($urandom), 1'b1);
        do_xfer(2'd3, 1'b0, 9'd7);   // R4 code 3 is pseudo
        do_xfer(2'd1, 1'b0, 9'd0);

        // R2 R3 R7: read from 500 across the wrap; flag holds 1
        do_xfer(2'd0, 1'b0, 9'd500);
        for (int k = 0; k < 20; k++) ser_step(4'h0, (k % 7) != 3);
        // R7: across 255 to 256 the flag stays 0
        do_xfer(2'd0, 1'b0, 9'd250);
        for (int k = 0; k < 12; k++) ser_step(4'h0, 1'b1);

        // R9 R10 R6: split refill of the lower half, then crossings
        do_xfer(2'd0, 1'b1, 9'h010);
        for (int k = 0; k < 260; k++) ser_step(4'h0, 1'b1);
        do_xfer(2'd0, 1'b1, 9'h1F0);
        for (int k = 0; k < 40; k++) ser_step(4'h0, 1'b1);
        do_xfer(2'd2, 1'b0, 9'd510);  // R10 leaves split mode
        for (int k = 0; k < 4; k++) ser_step(4'($urandom), 1'b1);

        // R11: transfer and step in the same cycle
        @(negedge clk);
        fill_row();
        xfer_req = 1'b1; xfer_kind = 2'd0; xfer_split = 1'b0; xfer_tap = 9'd77; sclk = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0; sclk = 1'b0;
        model_xfer(2'd0, 1'b0, 9'd77);
        #1;
        check(sd_out == m_mem[77], "R11 transfer wins", 32'(sd_out), 32'(m_mem[77]));
        for (int k = 0; k < 3; k++) ser_step(4'h0, 1'b1);

        // random mix
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom_range(0, 11);
            case (r)
                0: do_xfer(2'd0, 1'b0, 9'($urandom));
                1: do_xfer(2'd0, 1'b1, 9'($urandom));
                2: do_xfer(2'd1, 1'b0, 9'($urandom));
                3: do_xfer(2'd2, 1'b0, 9'($urandom));
                default: ser_step(4'($urandom), $urandom_range(0, 3) != 0);
            endcase
        end
        do_xfer(2'd1, 1'b0, 9'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule